// File: doc/BRIEF.md
# Dual Limit-Reload Microsecond Timer

This block holds two independent counter/timer channels. A shared prescaler divides the system clock into a periodic tick, one per microsecond by default. Each running channel advances its counter by one on every tick. When the next value would reach the programmed limit, the counter goes back to 1 instead of 0, and the channel raises its limit-reached flag. The counter therefore runs 1, 2, …, L-1, and a period of N ticks needs a limit of N+1. Each channel's flag drives one interrupt line. Channel 0 drives the level-10 line and channel 1 drives the level-14 line.

Software reaches every channel through a single-cycle register bus. Each channel has a counter register, a limit register that restarts the count, a limit register that leaves the count running, and a run-control register. Counter and limit words share one packed layout: the flag sits in the top bit and the count sits in a shifted field. A build parameter switches the field to a 22-bit count in half-microsecond steps.

Top module: `usec_timer_pair`

## Requirements
- R1: After reset each counter reads 1, each limit reads 0, each run bit reads 0, both interrupt lines are low and read data is 0.
- R2: The bus address bit 2 selects the channel. Address bits 1:0 select the register: 0 = counter, 1 = restarting limit, 2 = non-restarting limit, 3 = run (bit 0). A counter or limit word carries the flag in bit 31, the count in bits 30:10 and zeros in bits 9:0. Read data appears in the cycle after the read request.
- R3: While running with a limit L of 2 or more, each tick moves the counter to count+1. If count+1 >= L, the counter instead reloads to 1 and the flag sets. The period is L-1 ticks.
- R4: With default parameters, the prescaler produces one tick every 4 clock cycles (CLKS_PER_US).
- R5: While the run bit is 0, the counter holds its value.
- R6: A limit of 0 or 1 disables the channel: the counter holds and the flag never sets.
- R7: A write to the restarting limit loads the limit, sets the counter to 1 and clears the flag.
- R8: A write to the non-restarting limit loads the limit and leaves the counter and its sequence undisturbed.
- R9: A read of either limit register returns the flag and the limit, then clears the flag. A new limit event in the same cycle keeps the flag set.
- R10: Channel 0's flag drives irq_lvl10 and channel 1's flag drives irq_lvl14. Each channel runs independently of the other.
- R11: A counter write loads the count field from the write data. Bits 31 and 9:0 of the written word are ignored.
- R12: With HALF_US set, the count field is 22 bits wide at bits 30:9 and the tick comes every CLKS_PER_US/2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Bit 2 selects the channel, bits 1:0 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_lvl10 | output | 1 | Channel 0 limit interrupt |
| irq_lvl14 | output | 1 | Channel 1 limit interrupt |

## Verification
Read data is due one clock after the request, so the scoreboard monitor compares the queued expectation at the falling edge after the next rising edge. A limit event raises the interrupt at the tick edge itself. The bench synchronises to that rising edge and then places every counter read at a fixed offset of whole tick periods (4 clocks) from it. A limit read clears the interrupt at its sampling edge, and the line is checked low half a cycle later. Periods are measured in clock cycles between two interrupt rises and compared against (limit-1) times the tick division.

// File: rtl/utp_pkg.sv
package utp_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT      = 2'd0,
    SEL_LIMIT      = 2'd1,
    SEL_LIMIT_KEEP = 2'd2,
    SEL_RUN        = 2'd3
  } reg_sel_e;

  // Place a count field at bit position lsb under the flag bit.
  function automatic logic [31:0] pack_word(input logic flag, input logic [30:0] field,
                                            input int unsigned lsb);
    logic [30:0] sh;
    sh = field << lsb;
    return {flag, sh};
  endfunction

  // Recover the count field from a bus word (flag bit excluded).
  function automatic logic [30:0] unpack_field(input logic [30:0] w, input int unsigned lsb);
    return w >> lsb;
  endfunction

endpackage

// File: rtl/utp_prescaler.sv
module utp_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + 1'b1;
      end
      assign tick = (phase == LAST);
    end
  endgenerate
endmodule

// File: rtl/utp_channel.sv
module utp_channel #(
  parameter int unsigned CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_cnt,
  input  logic          wr_lim,
  input  logic          wr_keep,
  input  logic          wr_run,
  input  logic          rd_lim,
  input  logic [CW-1:0] ld_value,
  input  logic          ld_run,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] lim,
  output logic          flag,
  output logic          run,
  output logic          wrap
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  logic          enabled;
  logic          advance;
  logic [CW:0]   nxt;
  logic          at_limit;

  assign enabled  = (lim >= TWO);
  assign nxt      = {1'b0, cnt} + 1'b1;
  assign at_limit = (nxt >= {1'b0, lim});
  assign advance  = tick && run && enabled && !wr_cnt && !wr_lim;
  assign wrap     = advance && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= ONE;
      lim  <= '0;
      flag <= 1'b0;
      run  <= 1'b0;
    end else begin
      if (wr_lim || wr_keep) lim <= ld_value;

      if (wr_cnt)        cnt <= ld_value;
      else if (wr_lim)   cnt <= ONE;
      else if (advance)  cnt <= at_limit ? ONE : nxt[CW-1:0];

      if (wrap)                  flag <= 1'b1;
      else if (rd_lim || wr_lim) flag <= 1'b0;

      if (wr_run) run <= ld_run;
    end
  end
endmodule

// File: rtl/usec_timer_pair.sv
module usec_timer_pair
  import utp_pkg::*;
#(
  parameter bit          HALF_US     = 1'b0,
  parameter int unsigned CLKS_PER_US = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_lvl10,
  output logic        irq_lvl14
);
  localparam int unsigned NCH      = 2;
  localparam int unsigned CW       = HALF_US ? 22 : 21;
  localparam int unsigned LSB      = HALF_US ? 9 : 10;
  localparam int unsigned HALF_DIV = (CLKS_PER_US / 2 > 0) ? CLKS_PER_US / 2 : 1;
  localparam int unsigned TICK_DIV = HALF_US ? HALF_DIV : CLKS_PER_US;

  logic                     tick;
  logic [NCH-1:0][CW-1:0]   ch_cnt, ch_lim;
  logic [NCH-1:0]           ch_flag, ch_run, ch_wrap;
  logic [NCH-1:0]           wr_cnt, wr_lim, wr_keep, wr_run, rd_lim;
  logic [CW-1:0]            ld_value;
  reg_sel_e                 rsel;
  logic                     csel;
  logic [31:0]              rd_word;
  logic                     unused_wbit;

  assign rsel        = reg_sel_e'(bus_addr[1:0]);
  assign csel        = bus_addr[2];
  assign ld_value    = CW'(unpack_field(bus_wdata[30:0], LSB));
  assign unused_wbit = bus_wdata[31];

  utp_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit        = bus_req && (csel == 1'(g));
    assign wr_cnt[g]  = hit && bus_we  && (rsel == SEL_COUNT);
    assign wr_lim[g]  = hit && bus_we  && (rsel == SEL_LIMIT);
    assign wr_keep[g] = hit && bus_we  && (rsel == SEL_LIMIT_KEEP);
    assign wr_run[g]  = hit && bus_we  && (rsel == SEL_RUN);
    assign rd_lim[g]  = hit && !bus_we && (rsel == SEL_LIMIT || rsel == SEL_LIMIT_KEEP);

    utp_channel #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_cnt  (wr_cnt[g]),
      .wr_lim  (wr_lim[g]),
      .wr_keep (wr_keep[g]),
      .wr_run  (wr_run[g]),
      .rd_lim  (rd_lim[g]),
      .ld_value(ld_value),
      .ld_run  (bus_wdata[0]),
      .cnt     (ch_cnt[g]),
      .lim     (ch_lim[g]),
      .flag    (ch_flag[g]),
      .run     (ch_run[g]),
      .wrap    (ch_wrap[g])
    );
  end

  always_comb begin
    case (rsel)
      SEL_COUNT:      rd_word = pack_word(ch_flag[csel], 31'(ch_cnt[csel]), LSB);
      SEL_LIMIT,
      SEL_LIMIT_KEEP: rd_word = pack_word(ch_flag[csel], 31'(ch_lim[csel]), LSB);
      SEL_RUN:        rd_word = {31'b0, ch_run[csel]};
      default:        rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bus_rdata <= '0;
    else if (bus_req && !bus_we) bus_rdata <= rd_word;
  end

  assign irq_lvl10 = ch_flag[0];
  assign irq_lvl14 = ch_flag[1];

endmodule

// File: rtl/usec_timer_pair_chk.sv
module usec_timer_pair_chk #(
  parameter int unsigned CW  = 21,
  parameter int unsigned TD  = 4,
  parameter int unsigned NCH = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0]         wrap,
  input logic [NCH-1:0]         flag,
  input logic [NCH-1:0]         wr_cnt,
  input logic [NCH-1:0]         wr_lim,
  input logic [NCH-1:0]         wr_keep,
  input logic [NCH-1:0]         rd_lim,
  input logic [NCH-1:0][CW-1:0] cnt,
  input logic [NCH-1:0][CW-1:0] lim
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    // R3
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[g] |=> (cnt[g] == CW'(1)) && flag[g])
      else $error("wrap_reload_chk ch%0d", g);

    // R3
    below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && run[g] && (lim[g] >= CW'(2)) && !wr_cnt[g] && !wr_lim[g] && !wr_keep[g]
      |=> cnt[g] < lim[g])
      else $error("below_limit_chk ch%0d", g);

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run[g] && !wr_cnt[g] && !wr_lim[g] |=> $stable(cnt[g]))
      else $error("halt_hold_chk ch%0d", g);

    // R6
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lim[g] < CW'(2)) && !wr_cnt[g] && !wr_lim[g] |=> $stable(cnt[g]) && !$rose(flag[g]))
      else $error("disabled_chk ch%0d", g);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lim[g] |=> (cnt[g] == CW'(1)) && !flag[g])
      else $error("restart_chk ch%0d", g);

    // R8
    keep_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_keep[g] && !(tick && run[g]) |=> $stable(cnt[g]))
      else $error("keep_count_chk ch%0d", g);

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lim[g] && !wrap[g] |=> !flag[g])
      else $error("read_clear_chk ch%0d", g);
  end

  if (TD > 1) begin : g_tick
    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick)
      else $error("tick_gap_chk");
  end
endmodule

bind usec_timer_pair usec_timer_pair_chk #(.CW(CW), .TD(TICK_DIV), .NCH(NCH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .run    (ch_run),
  .wrap   (ch_wrap),
  .flag   (ch_flag),
  .wr_cnt (wr_cnt),
  .wr_lim (wr_lim),
  .wr_keep(wr_keep),
  .rd_lim (rd_lim),
  .cnt    (ch_cnt),
  .lim    (ch_lim)
);

// File: tb/usec_timer_pair_bench.sv
module usec_timer_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_h;
  logic        irq10, irq14, irq10_h, irq14_h;

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  logic [31:0] last_rd = '0;

  always #5 clk = ~clk;

  usec_timer_pair u_usec_timer_pair (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_lvl10(irq10), .irq_lvl14(irq14));

  usec_timer_pair #(.HALF_US(1'b1)) u_usec_timer_pair_half (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_h), .irq_lvl10(irq10_h), .irq_lvl14(irq14_h));

  localparam logic [1:0] A_CNT = 2'd0, A_LIM = 2'd1, A_KEEP = 2'd2, A_RUN = 2'd3;
  localparam int TICK = 4;

  function automatic logic [31:0] enc(input bit f, input int unsigned v);
    return {f, 21'(v), 10'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  typedef struct { logic [31:0] val; bit cmp; string tag; } exp_t;
  exp_t sb_q[$];
  logic pend = 1'b0;

  always @(posedge clk) pend <= req && !we;

  always @(negedge clk) begin
    if (pend) begin
      exp_t e;
      if (sb_q.size() == 0) chk(1'b0, "scoreboard empty R2", rdata, '0);
      else begin
        e = sb_q.pop_front();
        if (e.cmp) chk(rdata === e.val, e.tag, rdata, e.val);
        else last_rd = rdata;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input bit ch, input logic [1:0] r, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = {ch, r}; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input bit ch, input logic [1:0] r, input logic [31:0] e,
                        input bit cmp, input string tag);
    exp_t x;
    x.val = e; x.cmp = cmp; x.tag = tag;
    req = 1'b1; we = 1'b0; addr = {ch, r};
    sb_q.push_back(x);
    @(negedge clk);
    req = 1'b0;
  endtask

  function automatic logic irq_of(input bit ch, input bit half);
    if (half) return ch ? irq14_h : irq10_h;
    return ch ? irq14 : irq10;
  endfunction

  task automatic wait_rise(input bit ch, input bit half, output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!irq_of(ch, half) && c < 5000);
  endtask

  // Measures the cycles between two interrupt rises, clearing the flag in between.
  task automatic period(input bit ch, input int unsigned fld, input int lsb, input bit half,
                        input int exp_cyc, input string tag);
    int c;
    bus_wr(ch, A_LIM, 32'(fld) << lsb);
    bus_wr(ch, A_RUN, 32'd1);
    wait_rise(ch, half, c);
    bus_rd(ch, A_LIM, '0, 1'b0, tag);
    wait_rise(ch, half, c);
    chk(c + 1 == exp_cyc, tag, 32'(c + 1), 32'(exp_cyc));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      chk(1'b0, "watchdog expired", 32'(cyc), '0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    int c;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state, R2 layout, R12 half-step field position
    chk(rdata === 32'h0, "R1 rdata after reset", rdata, 32'h0);
    chk(!irq10 && !irq14, "R1 irqs low", {30'b0, irq14, irq10}, '0);
    bus_rd(1'b0, A_CNT, enc(0, 1), 1'b1, "R1 ch0 counter");
    chk(rdata_h === (32'd1 << 9), "R12 half-mode counter field at bit 9", rdata_h, 32'd1 << 9);
    bus_rd(1'b0, A_LIM, enc(0, 0), 1'b1, "R1 ch0 limit");
    bus_rd(1'b0, A_RUN, 32'h0, 1'b1, "R1 ch0 run");
    bus_rd(1'b1, A_CNT, enc(0, 1), 1'b1, "R1 ch1 counter");

    // R5 stopped channel with a valid limit does not count
    bus_wr(1'b0, A_LIM, enc(0, 4));
    idle(20);
    bus_rd(1'b0, A_CNT, enc(0, 1), 1'b1, "R5 stopped counter holds");
    chk(!irq10, "R5 no irq while stopped", {31'b0, irq10}, '0);

    // R3 sequence 1,2,3,1 with limit 4; R9 read-clear; R10 independence
    bus_wr(1'b0, A_RUN, 32'd1);
    wait_rise(1'b0, 1'b0, c);
    bus_rd(1'b0, A_CNT, enc(1, 1), 1'b1, "R3 reload to 1 with flag");
    bus_rd(1'b0, A_LIM, enc(1, 4), 1'b1, "R9 limit read shows flag");
    chk(!irq10, "R9 irq cleared by limit read", {31'b0, irq10}, '0);
    idle(2);
    bus_rd(1'b0, A_CNT, enc(0, 2), 1'b1, "R3 count 2");
    idle(3);
    bus_rd(1'b0, A_CNT, enc(0, 3), 1'b1, "R3 count 3");
    idle(3);
    chk(irq10, "R3 flag set on second limit", {31'b0, irq10}, 32'd1);
    bus_rd(1'b0, A_CNT, enc(1, 1), 1'b1, "R3 back to 1");
    chk(!irq14, "R10 ch1 unaffected", {31'b0, irq14}, '0);

    // R7 restart write, R8 non-restarting limit
    bus_wr(1'b0, A_LIM, enc(0, 6));
    wait_rise(1'b0, 1'b0, c);
    bus_rd(1'b0, A_LIM, enc(1, 6), 1'b1, "R7 restarted limit value");
    idle(3);
    bus_wr(1'b0, A_KEEP, enc(0, 3));
    bus_rd(1'b0, A_CNT, enc(0, 2), 1'b1, "R8 count kept after keep-limit write");
    idle(2);
    chk(irq10, "R8 new limit takes effect", {31'b0, irq10}, 32'd1);
    bus_rd(1'b0, A_CNT, enc(1, 1), 1'b1, "R8 wrap at new limit");
    bus_rd(1'b0, A_KEEP, enc(1, 3), 1'b1, "R9 keep-limit read value");
    chk(!irq10, "R9 keep-limit read clears irq", {31'b0, irq10}, '0);

    // R5 halt mid-count, R7 restart to 1
    bus_wr(1'b0, A_LIM, enc(0, 100));
    bus_rd(1'b0, A_RUN, 32'd1, 1'b1, "R2 run bit reads 1");
    idle(20);
    bus_wr(1'b0, A_RUN, 32'd0);
    bus_rd(1'b0, A_CNT, '0, 1'b0, "R5 snapshot");
    idle(1);
    held = last_rd;
    chk(held[30:10] > 21'd1, "R3 counter advanced", held, enc(0, 2));
    idle(30);
    bus_rd(1'b0, A_CNT, held, 1'b1, "R5 count held while stopped");
    bus_wr(1'b0, A_LIM, enc(0, 100));
    bus_rd(1'b0, A_CNT, enc(0, 1), 1'b1, "R7 restarting write sets counter 1");

    // R3/R4 period is (limit-1) ticks of 4 clocks; R10 channel 1 on level-14 line
    period(1'b1, 3, 10, 1'b0, 2 * TICK, "R10 ch1 period N=2");
    period(1'b0, 6, 10, 1'b0, 5 * TICK, "R4 ch0 period N=5");
    period(1'b0, 2, 10, 1'b0, 1 * TICK, "R3 ch0 period N=1");

    // R6 limits 1 and 0 disable
    bus_wr(1'b1, A_LIM, enc(0, 1));
    idle(30);
    chk(!irq14, "R6 limit 1 no irq", {31'b0, irq14}, '0);
    bus_rd(1'b1, A_CNT, enc(0, 1), 1'b1, "R6 limit 1 counter holds");
    bus_wr(1'b1, A_LIM, enc(0, 0));
    idle(30);
    chk(!irq14, "R6 limit 0 no irq", {31'b0, irq14}, '0);
    bus_rd(1'b1, A_CNT, enc(0, 1), 1'b1, "R6 limit 0 counter holds");

    // R11 counter write
    bus_wr(1'b1, A_RUN, 32'd0);
    bus_rd(1'b1, A_RUN, 32'd0, 1'b1, "R2 run bit reads 0");
    bus_wr(1'b1, A_CNT, 32'hFFFF_FFFF);
    bus_rd(1'b1, A_CNT, 32'h7FFF_FC00, 1'b1, "R11 flag and low bits ignored");
    bus_wr(1'b1, A_CNT, enc(0, 7));
    bus_rd(1'b1, A_CNT, enc(0, 7), 1'b1, "R11 counter load");

    // R12 half-step mode: limit 5 -> 4 half-ticks of 2 clocks
    period(1'b1, 5, 9, 1'b1, 8, "R12 half-mode period");

    idle(2);
    chk(sb_q.size() == 0, "R2 all reads answered", 32'(sb_q.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule